// File: doc/BRIEF.md
# Row Retirement Address Enumerator

When a memory error is reported against one DRAM location, every location that shares the same physical DRAM row has to be taken out of service. This block takes the error-report DRAM address and walks through all addresses in that row. It replaces the 5-bit column field with each of its 32 values. It then inverts the address bit that carries row bit 13 and walks the 32 column values a second time, for 64 candidates in all.

Each candidate goes out on a valid/ready request to an external translator, and only one request is in flight at a time. The translator answers with a system address or an error. For a good answer, the block forms the page number and asks a page-status lookup whether that page is online and whether it is already poisoned. Pages that pass both tests leave on the retire output. At the end of the sweep the block pulses done and holds the counts of emitted and skipped candidates.

Top module: `row_retire_sweep`

## Requirements
- R1: After reset, no request, retire or done is raised, busy is low, and both counts read zero.
- R2: A start pulse while idle captures the error address. Candidate k (k = 0..63, issued in rising k) equals that address with bits [5:1] replaced by k mod 32. For k of 32 and above, bit 23 is also inverted. All other bits are unchanged.
- R3: A request holds its valid and address until it is accepted. No new request is raised until the response to the previous one has arrived.
- R4: A response with the error flag set skips that candidate: the skipped count rises by one and nothing is retired.
- R5: A translated page that the status lookup reports as not online, or as already poisoned, is skipped and not retired. The lookup key is the page number of that response.
- R6: Every other translated page is emitted as a one-cycle retire pulse, in candidate order. The page number is the translated address bits [47:12].
- R7: Once the last candidate is resolved, done pulses for exactly one cycle. At that point emitted plus skipped equals 64, and both counts then hold until the next start.
- R8: A start pulse while a sweep is busy is ignored: the sweep goes on with the address captured first.
- R9: A translator response that arrives while no request is outstanding is ignored: it raises no retire, changes no count and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a sweep (taken only when idle) |
| err_addr_i | input | ADDR_W (28) | Error-report DRAM address |
| busy_o | output | 1 | Sweep in progress |
| xreq_valid_o | output | 1 | Translation request valid |
| xreq_ready_i | input | 1 | Translator accepts the request |
| xreq_addr_o | output | ADDR_W (28) | Candidate DRAM address |
| xrsp_valid_i | input | 1 | Translation response valid |
| xrsp_err_i | input | 1 | Translation failed |
| xrsp_addr_i | input | SYS_W (48) | Translated system address |
| pq_pfn_o | output | SYS_W-PAGE_SHIFT (36) | Page number under status lookup |
| pq_online_i | input | 1 | Looked-up page is online |
| pq_poisoned_i | input | 1 | Looked-up page is already poisoned |
| retire_valid_o | output | 1 | Retire pulse |
| retire_pfn_o | output | SYS_W-PAGE_SHIFT (36) | Page number to retire |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| emitted_o | output | 7 | Pages emitted in the last sweep |
| skipped_o | output | 7 | Candidates skipped in the last sweep |

## Verification
A wrong column counter or pass bit shows up on the next accepted request, because its address no longer matches the expected candidate. A state machine that loses its place appears within one cycle as a second request while one is pending, or as a retire pulse that is missing or in the wrong place. An error in the skip decision shows up as a retire sequence that differs from the independently computed list, and at the done pulse as wrong counts. Spurious responses while idle and start pulses during a sweep check that no stray state change reaches the ports.

// File: rtl/rr_pkg.sv
package rr_pkg;

    // Sweep controller states; the idle encoding is zero so a cleared
    // register means idle.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_CHECK = 3'd3,
        ST_EMIT  = 3'd4,
        ST_DONE  = 3'd5
    } rr_state_e;

endpackage

// File: rtl/rr_cand_gen.sv
// Builds one candidate address: column field overwritten by the sweep
// count, the row-flip bit inverted during the second pass.
module rr_cand_gen #(
    parameter int ADDR_W   = 28,
    parameter int COL_LSB  = 1,
    parameter int COL_W    = 5,
    parameter int FLIP_BIT = 23
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              pass_i,
    output logic [ADDR_W-1:0] cand_o
);

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b >= COL_LSB && b < COL_LSB + COL_W) begin : g_col
            assign cand_o[b] = col_i[b-COL_LSB];
        end else if (b == FLIP_BIT) begin : g_flip
            assign cand_o[b] = base_i[b] ^ pass_i;
        end else begin : g_keep
            assign cand_o[b] = base_i[b];
        end
    end

endmodule

// File: rtl/rr_page_filter.sv
// Page number extraction and keep/skip decision for one translated page.
module rr_page_filter #(
    parameter int SYS_W      = 48,
    parameter int PAGE_SHIFT = 12,
    localparam int PFN_W     = SYS_W - PAGE_SHIFT
) (
    input  logic [SYS_W-1:0] sys_addr_i,
    output logic [PFN_W-1:0] pfn_o,
    input  logic             online_i,
    input  logic             poisoned_i,
    output logic             keep_o
);

    assign pfn_o  = sys_addr_i[SYS_W-1:PAGE_SHIFT];
    assign keep_o = online_i & ~poisoned_i;

endmodule

// File: rtl/row_retire_sweep.sv
module row_retire_sweep
    import rr_pkg::*;
#(
    parameter int ADDR_W     = 28,
    parameter int SYS_W      = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int COL_LSB    = 1,
    parameter int COL_W      = 5,
    parameter int FLIP_BIT   = 23,
    localparam int PFN_W     = SYS_W - PAGE_SHIFT,
    localparam int TOTAL     = 2 * (1 << COL_W),
    localparam int CNT_W     = $clog2(TOTAL + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] err_addr_i,
    output logic              busy_o,
    output logic              xreq_valid_o,
    input  logic              xreq_ready_i,
    output logic [ADDR_W-1:0] xreq_addr_o,
    input  logic              xrsp_valid_i,
    input  logic              xrsp_err_i,
    input  logic [SYS_W-1:0]  xrsp_addr_i,
    output logic [PFN_W-1:0]  pq_pfn_o,
    input  logic              pq_online_i,
    input  logic              pq_poisoned_i,
    output logic              retire_valid_o,
    output logic [PFN_W-1:0]  retire_pfn_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  emitted_o,
    output logic [CNT_W-1:0]  skipped_o
);

    typedef struct packed {
        rr_state_e          state;
        logic [ADDR_W-1:0]  base;
        logic [COL_W-1:0]   col;
        logic               pass;
        logic [PFN_W-1:0]   pfn;
        logic [CNT_W-1:0]   emitted;
        logic [CNT_W-1:0]   skipped;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic [ADDR_W-1:0] cand_w;
    logic [PFN_W-1:0]  rsp_pfn_w;
    logic              keep_w;
    logic              last_col_w;
    rr_state_e         adv_state_w;

    rr_cand_gen #(
        .ADDR_W   (ADDR_W),
        .COL_LSB  (COL_LSB),
        .COL_W    (COL_W),
        .FLIP_BIT (FLIP_BIT)
    ) i_cand (
        .base_i (cur_q.base),
        .col_i  (cur_q.col),
        .pass_i (cur_q.pass),
        .cand_o (cand_w)
    );

    rr_page_filter #(
        .SYS_W      (SYS_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) i_filter (
        .sys_addr_i (xrsp_addr_i),
        .pfn_o      (rsp_pfn_w),
        .online_i   (pq_online_i),
        .poisoned_i (pq_poisoned_i),
        .keep_o     (keep_w)
    );

    assign last_col_w  = &cur_q.col;
    assign adv_state_w = (last_col_w && cur_q.pass) ? ST_DONE : ST_ISSUE;

    always_comb begin
        nxt_d          = cur_q;
        xreq_valid_o   = 1'b0;
        retire_valid_o = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    nxt_d.state   = ST_ISSUE;
                    nxt_d.base    = err_addr_i;
                    nxt_d.col     = '0;
                    nxt_d.pass    = 1'b0;
                    nxt_d.emitted = '0;
                    nxt_d.skipped = '0;
                end
            end
            ST_ISSUE: begin
                xreq_valid_o = 1'b1;
                if (xreq_ready_i) begin
                    nxt_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (xrsp_valid_i) begin
                    if (xrsp_err_i) begin
                        nxt_d.skipped = cur_q.skipped + 1'b1;
                        nxt_d.col     = cur_q.col + 1'b1;
                        nxt_d.pass    = cur_q.pass | last_col_w;
                        nxt_d.state   = adv_state_w;
                    end else begin
                        nxt_d.pfn   = rsp_pfn_w;
                        nxt_d.state = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                nxt_d.col  = cur_q.col + 1'b1;
                nxt_d.pass = cur_q.pass | last_col_w;
                if (keep_w) begin
                    nxt_d.state = ST_EMIT;
                    nxt_d.col   = cur_q.col;
                    nxt_d.pass  = cur_q.pass;
                end else begin
                    nxt_d.skipped = cur_q.skipped + 1'b1;
                    nxt_d.state   = adv_state_w;
                end
            end
            ST_EMIT: begin
                retire_valid_o = 1'b1;
                nxt_d.emitted  = cur_q.emitted + 1'b1;
                nxt_d.col      = cur_q.col + 1'b1;
                nxt_d.pass     = cur_q.pass | last_col_w;
                nxt_d.state    = adv_state_w;
            end
            ST_DONE: begin
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o       = (cur_q.state != ST_IDLE);
    assign done_o       = (cur_q.state == ST_DONE);
    assign xreq_addr_o  = cand_w;
    assign pq_pfn_o     = cur_q.pfn;
    assign retire_pfn_o = cur_q.pfn;
    assign emitted_o    = cur_q.emitted;
    assign skipped_o    = cur_q.skipped;

    // Bits of a candidate that must always come from the captured address.
    function automatic logic [ADDR_W-1:0] fixed_bits();
        logic [ADDR_W-1:0] m;
        m = '1;
        for (int b = COL_LSB; b < COL_LSB + COL_W; b++) m[b] = 1'b0;
        m[FLIP_BIT] = 1'b0;
        return m;
    endfunction
    localparam logic [ADDR_W-1:0] FIXED_MASK = fixed_bits();

    assert_cand_base_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xreq_valid_o |-> ((xreq_addr_o & FIXED_MASK) == (cur_q.base & FIXED_MASK)));

    assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xreq_valid_o && !xreq_ready_i) |=> (xreq_valid_o && $stable(xreq_addr_o)));

    assert_single_outstanding_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xreq_valid_o && xreq_ready_i) |=> !xreq_valid_o);

    assert_err_no_retire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xrsp_valid_i && xrsp_err_i && cur_q.state == ST_WAIT) |=> !retire_valid_o);

    assert_bad_page_skip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.state == ST_CHECK && (!pq_online_i || pq_poisoned_i)) |=> !retire_valid_o);

    assert_retire_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_valid_o |=> !retire_valid_o);

    assert_done_total_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((CNT_W+1)'(emitted_o) + (CNT_W+1)'(skipped_o) == (CNT_W+1)'(TOTAL)));

    assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(cur_q.base));

    assert_idle_rsp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> (!busy_o && $stable(emitted_o) && $stable(skipped_o)));

endmodule

// File: tb/test_row_retire_sweep.sv
`timescale 1ns/1ps
module test_row_retire_sweep;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [27:0] err_addr_i = '0;
    logic        busy_o;
    logic        xreq_valid_o;
    logic        xreq_ready_i = 1'b0;
    logic [27:0] xreq_addr_o;
    logic        xrsp_valid_i = 1'b0;
    logic        xrsp_err_i = 1'b0;
    logic [47:0] xrsp_addr_i = '0;
    logic [35:0] pq_pfn_o;
    logic        pq_online_i;
    logic        pq_poisoned_i;
    logic        retire_valid_o;
    logic [35:0] retire_pfn_o;
    logic        done_o;
    logic [6:0]  emitted_o;
    logic [6:0]  skipped_o;

    always #2.5 clk = ~clk;

    row_retire_sweep i_row_retire_sweep (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .start_i        (start_i),
        .err_addr_i     (err_addr_i),
        .busy_o         (busy_o),
        .xreq_valid_o   (xreq_valid_o),
        .xreq_ready_i   (xreq_ready_i),
        .xreq_addr_o    (xreq_addr_o),
        .xrsp_valid_i   (xrsp_valid_i),
        .xrsp_err_i     (xrsp_err_i),
        .xrsp_addr_i    (xrsp_addr_i),
        .pq_pfn_o       (pq_pfn_o),
        .pq_online_i    (pq_online_i),
        .pq_poisoned_i  (pq_poisoned_i),
        .retire_valid_o (retire_valid_o),
        .retire_pfn_o   (retire_pfn_o),
        .done_o         (done_o),
        .emitted_o      (emitted_o),
        .skipped_o      (skipped_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit summary_done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model of the surroundings, written from the requirements.
    function automatic logic [27:0] cand_of(input logic [27:0] base, input int k);
        logic [27:0] a;
        a = base;
        a[5:1] = 5'(k % 32);
        if (k >= 32) a[23] = ~a[23];
        return a;
    endfunction

    function automatic logic [47:0] sys_of(input logic [3:0] mode, input logic [27:0] c);
        return {4'h0, mode, c, 12'h5A5};
    endfunction

    function automatic bit xl_err(input logic [3:0] mode, input logic [27:0] c);
        case (mode)
            4'd1:    return c[1];
            4'd2:    return (c[5:1] % 5) == 0;
            4'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit online_of(input logic [35:0] p);
        return !(p[31:28] != 4'd0 && p[3:2] == 2'b11);
    endfunction

    function automatic bit poisoned_of(input logic [35:0] p);
        return (p[31:28] >= 4'd2) && (p[4:3] == 2'b01);
    endfunction

    assign pq_online_i   = online_of(pq_pfn_o);
    assign pq_poisoned_i = poisoned_of(pq_pfn_o);

    logic [27:0] cur_base = '0;
    logic [3:0]  cur_mode = '0;
    logic [35:0] exp_pfn [0:63];
    int          exp_emit = 0;
    int          req_cnt = 0;
    int          ret_cnt = 0;
    bit          spur = 1'b0;

    // Translator responder and output monitor, all at the falling edge.
    bit          seen_v = 1'b0;
    logic [27:0] prev_addr = '0;
    logic [27:0] pend_addr = '0;
    bit          pend = 1'b0;
    int          lat = 0;
    int          tick = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            pend = 1'b0;
            seen_v = 1'b0;
            xreq_ready_i = 1'b0;
            xrsp_valid_i = 1'b0;
        end else begin
            xrsp_valid_i = 1'b0;
            xrsp_err_i   = 1'b0;
            if (seen_v && xreq_ready_i) begin
                if (req_cnt < 64)
                    chk(prev_addr == cand_of(cur_base, req_cnt), "R2", "candidate address",
                        64'(prev_addr), 64'(cand_of(cur_base, req_cnt)));
                else
                    chk(1'b0, "R2", "request beyond the 64th", 64'(req_cnt), 64'd64);
                req_cnt++;
                pend = 1'b1;
                pend_addr = prev_addr;
                lat = tick % 3;
            end else if (seen_v && !(xreq_valid_o && xreq_addr_o == prev_addr)) begin
                chk(1'b0, "R3", "request dropped or changed before ready",
                    64'(xreq_addr_o), 64'(prev_addr));
            end
            if (pend && xreq_valid_o)
                chk(1'b0, "R3", "new request while one is outstanding", 64'd1, 64'd0);
            if (spur) begin
                xrsp_valid_i = 1'b1;
                xrsp_addr_i  = 48'h0000_1234_5000;
            end else if (pend) begin
                if (lat == 0) begin
                    xrsp_valid_i = 1'b1;
                    xrsp_err_i   = xl_err(cur_mode, pend_addr);
                    xrsp_addr_i  = sys_of(cur_mode, pend_addr);
                    pend = 1'b0;
                end else begin
                    lat--;
                end
            end
            if (retire_valid_o) begin
                chk(ret_cnt < exp_emit && retire_pfn_o == exp_pfn[ret_cnt % 64], "R6",
                    "retired page", 64'(retire_pfn_o), 64'(exp_pfn[ret_cnt % 64]));
                ret_cnt++;
            end
            seen_v    = xreq_valid_o;
            prev_addr = xreq_addr_o;
            tick++;
            xreq_ready_i = (tick % 4) != 1;
        end
    end

    // Stimulus table: {mode[3:0], error address[27:0]}.
    localparam logic [31:0] VEC [6] = '{
        {4'd0, 28'h0000000},
        {4'd1, 28'h0A5C3E7},
        {4'd2, 28'hFFFFFFF},
        {4'd3, 28'h1234560},
        {4'd4, 28'h8800000},
        {4'd2, 28'h07FF03E}
    };

    task automatic run_vec(input logic [27:0] base, input logic [3:0] mode, input bit poke);
        int n;
        int sk;
        int waitc;
        logic [6:0] em_hold;
        logic [6:0] sk_hold;
        n = 0;
        sk = 0;
        cur_base = base;
        cur_mode = mode;
        req_cnt = 0;
        ret_cnt = 0;
        for (int k = 0; k < 64; k++) begin
            logic [27:0] c;
            logic [35:0] p;
            c = cand_of(base, k);
            p = 36'(sys_of(mode, c) >> 12);
            if (xl_err(mode, c) || !online_of(p) || poisoned_of(p)) begin
                sk++;
            end else begin
                exp_pfn[n] = p;
                n++;
            end
        end
        exp_emit = n;
        @(negedge clk);
        start_i = 1'b1;
        err_addr_i = base;
        @(negedge clk);
        start_i = 1'b0;
        err_addr_i = ~base;
        waitc = 0;
        while (!done_o && waitc < 5000) begin
            start_i = (poke && waitc == 20);   // R8: start during a sweep
            @(negedge clk);
            waitc++;
        end
        start_i = 1'b0;
        chk(done_o, "R7", "done reached", 64'(done_o), 64'd1);
        chk(emitted_o == 7'(n), "R6", "emitted count", 64'(emitted_o), 64'(n));
        chk(skipped_o == 7'(sk), "R4", "R5 skipped count", 64'(skipped_o), 64'(sk));
        chk(req_cnt == 64, "R2", "requests issued", 64'(req_cnt), 64'd64);
        chk(ret_cnt == n, "R6", "retire pulses", 64'(ret_cnt), 64'(n));
        em_hold = emitted_o;
        sk_hold = skipped_o;
        @(negedge clk);
        chk(!done_o, "R7", "done is one cycle", 64'(done_o), 64'd0);
        chk(!busy_o, "R7", "idle after done", 64'(busy_o), 64'd0);
        @(negedge clk);
        chk(emitted_o == em_hold && skipped_o == sk_hold, "R7", "counts held",
            64'({emitted_o, skipped_o}), 64'({em_hold, sk_hold}));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!xreq_valid_o, "R1", "request after reset", 64'(xreq_valid_o), 64'd0);
        chk(!retire_valid_o, "R1", "retire after reset", 64'(retire_valid_o), 64'd0);
        chk(!done_o, "R1", "done after reset", 64'(done_o), 64'd0);
        chk(!busy_o, "R1", "busy after reset", 64'(busy_o), 64'd0);
        chk(emitted_o == 0 && skipped_o == 0, "R1", "counts after reset",
            64'({emitted_o, skipped_o}), 64'd0);

        for (int v = 0; v < 6; v++) begin
            run_vec(VEC[v][27:0], VEC[v][31:28], (v % 2) == 1);
        end

        // R9: stray response while idle
        begin
            logic [6:0] em0;
            logic [6:0] sk0;
            em0 = emitted_o;
            sk0 = skipped_o;
            @(posedge clk);
            spur = 1'b1;
            @(posedge clk);
            spur = 1'b0;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(!retire_valid_o && !busy_o && !xreq_valid_o, "R9", "stray response reaction",
                    64'({retire_valid_o, busy_o, xreq_valid_o}), 64'd0);
            end
            chk(emitted_o == em0 && skipped_o == sk0, "R9", "counts after stray response",
                64'({emitted_o, skipped_o}), 64'({em0, sk0}));
        end

        // Back-to-back sweep after the stray response still works (R2, R7).
        run_vec(28'h0800002, 4'd1, 1'b0);

        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!summary_done) begin
            summary_done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
        $finish;
    end

endmodule